// File: doc/BRIEF.md
# Touch Pad Matrix Scanner

This block scans a small pushbutton-style touch pad matrix on its own, with no help from the host. It steps one drive line at a time, looks at the sense lines, and holds the first touched pad it finds in two capture registers. One register holds the column code and the other holds the row code. Both codes are one-hot. A capture stays in place until the host reads it, and later scan results cannot overwrite it.

The host reaches the registers over an 8-bit, 8080-style bus with active-low read and write strobes and two address lines. Addresses with the upper address bit clear belong to another device, and the block never drives the bus for them. When the host raises the read strobe, both registers return to the no-touch pattern. The address may change while the strobe is low, so the host can read both codes in a single strobe. Writes carry no data into the block; they only acknowledge the interrupt.

A new capture lowers an active-low interrupt. A static input selects one of two interrupt behaviours. In level mode the line stays low until the host acknowledges. In pulse mode the line goes low for a fixed number of cycles.

Top module: `touch_pad_scanner`

## Requirements
- R1: Exactly one drive line is high at any time. Drive line 0 is high first after reset, and the block moves to the next line every SETTLE_CYC cycles, wrapping from line 2 back to line 0.
- R2: A touch is captured when the sense lines are non-zero in the last cycle of a drive slot and no capture is pending. The column register then takes a one-hot code of the lowest-numbered active sense line. The row register takes a one-hot code of the drive line that was active.
- R3: Read data is valid only while the synchronized read strobe is low and address bit 1 is 1. With address 2'b10 the bus carries {2'b11, column code[5:0]}. With address 2'b11 it carries {5'b11111, row code[2:0]}. Bus inputs pass through two synchronizer flops.
- R4: With no pending capture, the column read returns 8'hFF and the row read returns 8'hFF.
- R5: If the address changes from 2'b10 to 2'b11 while the read strobe stays low, the output data follows the new address.
- R6: A rising edge of the read strobe at the end of a strobe that addressed either register clears both registers to the no-touch value. A strobe with address bit 1 at 0 clears nothing and never enables the output.
- R7: While a capture is pending, new scan results do not change the registers.
- R8: In level mode (pulse_mode = 0), irq_n falls when a touch is captured. It stays low until a read strobe or a write strobe to either register rises. A write acknowledges the interrupt but leaves the capture in place.
- R9: In pulse mode (pulse_mode = 1), irq_n is low for exactly PULSE_CYC cycles per capture. No further pulse occurs until the registers have been read.
- R10: When rst_n is low, the interrupt goes inactive and both registers return to the no-touch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | Interrupt mode select: 0 level, 1 pulse |
| addr | input | 2 | Register address from the host bus |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_out | output | 8 | Read data; 8'hFF when not enabled |
| data_oe | output | 1 | High while the block drives read data |
| irq_n | output | 1 | Active-low touch interrupt |
| drive | output | 3 | One-hot pad drive lines |
| sense | input | 6 | Pad sense lines, one per column |

## Verification
The checker runs on every cycle and covers the following:
- one-hot drive lines;
- no-touch values whenever nothing is pending;
- one-hot codes while a capture is pending;
- registers that hold steady until a clearing strobe;
- the clear that follows a qualifying read edge;
- a level interrupt that stays low until acknowledged;
- the fixed upper bits of column data on the bus.

Some behaviours show only in the bench's directed scenarios:
- the order and timing of the scan;
- the lowest-column choice under multi-touch;
- data following an address change mid-strobe;
- the exact pulse width and the lack of a re-arm before a read;
- that foreign-address reads change nothing;
- that a write acknowledges without clearing.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int COL_W = 6;
    localparam int ROW_W = 3;
    localparam int BUS_W = 8;

    typedef struct packed {
        logic             pending;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             rd_prev;
        logic             wr_prev;
        logic             rd_hit;
        logic             wr_hit;
    } tps_regs_t;
endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
    parameter int         WIDTH   = 4,
    parameter int         STAGES  = 2,
    parameter logic [3:0] RST_VAL = 4'b1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = async_i;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL[WIDTH-1:0];
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tps_scan.sv
module tps_scan #(
    parameter int NUM_DRV    = 3,
    parameter int NUM_SNS    = 6,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SNS-1:0] sense_i,
    output logic [NUM_DRV-1:0] drive_o,
    output logic               hit_o,
    output logic [NUM_DRV-1:0] hit_row_o,
    output logic [NUM_SNS-1:0] hit_col_o
);
    localparam int IDX_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  slot_end;

    assign slot_end = (scan_q.cnt == CNT_W'(SETTLE_CYC - 1));

    always_comb begin
        scan_d = scan_q;
        if (slot_end) begin
            scan_d.cnt = '0;
            scan_d.idx = (scan_q.idx == IDX_W'(NUM_DRV - 1)) ? '0 : scan_q.idx + 1'b1;
        end else begin
            scan_d.cnt = scan_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    generate
        for (genvar g = 0; g < NUM_DRV; g++) begin : g_drive
            assign drive_o[g] = (scan_q.idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        hit_col_o = '0;
        for (int i = NUM_SNS - 1; i >= 0; i--) begin
            if (sense_i[i]) begin
                hit_col_o    = '0;
                hit_col_o[i] = 1'b1;
            end
        end
    end

    assign hit_o     = slot_end && (|sense_i);
    assign hit_row_o = drive_o;
endmodule

// File: rtl/tps_irq.sv
module tps_irq #(
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode_i,
    input  logic capture_i,
    input  logic ack_i,
    output logic irq_n_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic          flag;
        logic [PW-1:0] cnt;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack_i) irq_d.flag = 1'b0;
        if (capture_i && !pulse_mode_i) irq_d.flag = 1'b1;
        if (capture_i && pulse_mode_i) begin
            irq_d.cnt = PW'(PULSE_CYC);
        end else if (irq_q.cnt != '0) begin
            irq_d.cnt = irq_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_n_o = pulse_mode_i ? (irq_q.cnt == '0) : !irq_q.flag;
endmodule

// File: rtl/touch_pad_scanner.sv
module touch_pad_scanner
    import tps_pkg::*;
#(
    parameter int SETTLE_CYC  = 4,
    parameter int PULSE_CYC   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_mode,
    input  logic [1:0]       addr,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic [BUS_W-1:0] data_out,
    output logic             data_oe,
    output logic             irq_n,
    output logic [ROW_W-1:0] drive,
    input  logic [COL_W-1:0] sense
);
    logic [3:0]       bus_s;
    logic             rd_s, wr_s;
    logic [1:0]       addr_s;
    logic             hit;
    logic [ROW_W-1:0] hit_row;
    logic [COL_W-1:0] hit_col;
    logic             rd_rise, wr_rise, clr_rd, ack_wr, capture;
    tps_regs_t        reg_d, reg_q;

    tps_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .async_i({rd_n, wr_n, addr}),
        .sync_o(bus_s)
    );
    assign rd_s   = bus_s[3];
    assign wr_s   = bus_s[2];
    assign addr_s = bus_s[1:0];

    tps_scan #(.NUM_DRV(ROW_W), .NUM_SNS(COL_W), .SETTLE_CYC(SETTLE_CYC)) scan_i (
        .clk(clk), .rst_n(rst_n), .sense_i(sense), .drive_o(drive),
        .hit_o(hit), .hit_row_o(hit_row), .hit_col_o(hit_col)
    );

    assign rd_rise = rd_s && !reg_q.rd_prev;
    assign wr_rise = wr_s && !reg_q.wr_prev;
    assign clr_rd  = rd_rise && reg_q.rd_hit;
    assign ack_wr  = wr_rise && reg_q.wr_hit;
    assign capture = hit && !reg_q.pending && !clr_rd;

    always_comb begin
        reg_d         = reg_q;
        reg_d.rd_prev = rd_s;
        reg_d.wr_prev = wr_s;
        if (!rd_s && addr_s[1]) reg_d.rd_hit = 1'b1;
        else if (rd_rise)       reg_d.rd_hit = 1'b0;
        if (!wr_s && addr_s[1]) reg_d.wr_hit = 1'b1;
        else if (wr_rise)       reg_d.wr_hit = 1'b0;
        if (clr_rd) begin
            reg_d.pending = 1'b0;
            reg_d.col     = '1;
            reg_d.row     = '1;
        end else if (capture) begin
            reg_d.pending = 1'b1;
            reg_d.col     = hit_col;
            reg_d.row     = hit_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q         <= '0;
            reg_q.col     <= '1;
            reg_q.row     <= '1;
            reg_q.rd_prev <= 1'b1;
            reg_q.wr_prev <= 1'b1;
        end else begin
            reg_q <= reg_d;
        end
    end

    tps_irq #(.PULSE_CYC(PULSE_CYC)) irq_i (
        .clk(clk), .rst_n(rst_n), .pulse_mode_i(pulse_mode),
        .capture_i(capture), .ack_i(clr_rd || ack_wr), .irq_n_o(irq_n)
    );

    always_comb begin
        data_oe  = !rd_s && addr_s[1];
        data_out = '1;
        if (data_oe) begin
            if (addr_s[0]) data_out = {{(BUS_W-ROW_W){1'b1}}, reg_q.row};
            else           data_out = {{(BUS_W-COL_W){1'b1}}, reg_q.col};
        end
    end
endmodule

// File: rtl/tps_checker.sv
module tps_checker
    import tps_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pend,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic             clr,
    input logic             ack,
    input logic             pulse_mode,
    input logic             irq_n,
    input logic             data_oe,
    input logic [1:0]       addr_s,
    input logic [BUS_W-1:0] data_out,
    input logic [ROW_W-1:0] drive
);
    AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive) == 1);                                            // R1
    AST_CAPTURE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> ($countones(col) == 1 && $countones(row) == 1));           // R2
    AST_COL_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !addr_s[0]) |-> (data_out[BUS_W-1:COL_W] == '1));       // R3
    AST_IDLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> (col == '1 && row == '1));                                // R4
    AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);                                                     // R6
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(col) && $stable(row)));         // R7
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && !irq_n && !ack) |=> (pulse_mode || !irq_n));        // R8
endmodule

bind touch_pad_scanner tps_checker chk_i (
    .clk(clk), .rst_n(rst_n), .pend(reg_q.pending), .col(reg_q.col),
    .row(reg_q.row), .clr(clr_rd), .ack(clr_rd || ack_wr),
    .pulse_mode(pulse_mode), .irq_n(irq_n), .data_oe(data_oe),
    .addr_s(addr_s), .data_out(data_out), .drive(drive)
);

// File: tb/touch_pad_scanner_tb_top.sv
module touch_pad_scanner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int PULSE      = 3;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_mode = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] data_out;
    logic       data_oe;
    logic       irq_n;
    logic [2:0] drive;
    logic [5:0] sense;
    logic [5:0] pads [3];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        sense = '0;
        for (int r = 0; r < 3; r++) if (drive[r]) sense = sense | pads[r];
    end

    touch_pad_scanner #(.SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .data_out(data_out), .data_oe(data_oe),
        .irq_n(irq_n), .drive(drive), .sense(sense)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_pads();
        for (int r = 0; r < 3; r++) pads[r] = '0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!irq_n) begin seen = 1'b1; break; end
        end
    endtask

    task automatic read_pair(output logic [7:0] c, output logic [7:0] r);
        @(negedge clk); addr = 2'b10; rd_n = 1'b0;
        cycles(3); c = data_out;
        addr = 2'b11;
        cycles(3); r = data_out;
        rd_n = 1'b1;
        cycles(4);
    endtask

    task automatic do_reset();
        clear_pads();
        rst_n = 1'b0;
        cycles(5);
        rst_n = 1'b1;
    endtask

    task automatic test_reset_scan();
        logic [7:0] c, r;
        do_reset();
        for (int k = 0; k < 6 * SETTLE; k++) begin
            check("R1 drive order", {5'b0, drive}, 8'(3'b001 << ((k / SETTLE) % 3)));
            @(negedge clk);
        end
        check("R10 irq idle after reset", {7'b0, irq_n}, 8'h01);
        read_pair(c, r);
        check("R4 column idle", c, 8'hFF);
        check("R4 row idle", r, 8'hFF);
    endtask

    task automatic test_capture_read();
        bit seen; logic [7:0] c;
        pads[1] = 6'b010000;
        wait_irq(seen);
        check("R2 level irq on touch", {7'b0, seen}, 8'h01);
        clear_pads();
        cycles(2 * 3 * SETTLE);
        check("R8 level irq holds", {7'b0, irq_n}, 8'h00);
        @(negedge clk); addr = 2'b10; rd_n = 1'b0;
        cycles(3);
        check("R3 oe on column read", {7'b0, data_oe}, 8'h01);
        check("R3 column data", data_out, 8'hD0);
        addr = 2'b11;
        cycles(3);
        check("R5 data follows address", data_out, 8'hFA);
        check("R8 irq low during strobe", {7'b0, irq_n}, 8'h00);
        rd_n = 1'b1;
        cycles(4);
        check("R3 oe off after strobe", {7'b0, data_oe}, 8'h00);
        check("R8 irq released by read", {7'b0, irq_n}, 8'h01);
        @(negedge clk); addr = 2'b11; rd_n = 1'b0;
        cycles(3); c = data_out;
        rd_n = 1'b1; cycles(4);
        check("R6 row cleared by rising edge", c, 8'hFF);
    endtask

    task automatic test_hold();
        bit seen; logic [7:0] c, r;
        pads[0] = 6'b000001;
        wait_irq(seen);
        pads[0] = '0; pads[2] = 6'b100000;
        cycles(6 * SETTLE);
        clear_pads();
        read_pair(c, r);
        check("R7 column kept", c, 8'hC1);
        check("R7 row kept", r, 8'hF9);
    endtask

    task automatic test_other_device();
        bit seen; logic [7:0] c, r; logic oe_seen;
        pads[2] = 6'b000100;
        wait_irq(seen);
        clear_pads();
        @(negedge clk); addr = 2'b01; rd_n = 1'b0;
        oe_seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            oe_seen = oe_seen | data_oe;
        end
        check("R3 no drive for foreign address", {7'b0, oe_seen}, 8'h00);
        rd_n = 1'b1; cycles(4);
        check("R6 foreign read keeps irq", {7'b0, irq_n}, 8'h00);
        read_pair(c, r);
        check("R6 foreign read keeps column", c, 8'hC4);
        check("R6 foreign read keeps row", r, 8'hFC);
    endtask

    task automatic test_write_ack();
        bit seen; logic [7:0] c, r;
        pads[1] = 6'b000010;
        wait_irq(seen);
        clear_pads();
        @(negedge clk); addr = 2'b10; wr_n = 1'b0;
        cycles(3); wr_n = 1'b1; cycles(4);
        check("R8 write acknowledges irq", {7'b0, irq_n}, 8'h01);
        read_pair(c, r);
        check("R8 write leaves column", c, 8'hC2);
        check("R8 write leaves row", r, 8'hFA);
    endtask

    task automatic test_multi();
        bit seen; logic [7:0] c, r;
        pads[1] = 6'b100100;
        wait_irq(seen);
        clear_pads();
        read_pair(c, r);
        check("R2 lowest column chosen", c, 8'hC4);
        check("R2 row of multi touch", r, 8'hFA);
    endtask

    task automatic test_pulse();
        bit seen; int width; int extra; logic [7:0] c, r;
        pulse_mode = 1'b1;
        cycles(2);
        pads[0] = 6'b001000;
        wait_irq(seen);
        width = 0;
        while (!irq_n && width < 50) begin width++; @(negedge clk); end
        check("R9 pulse width", 8'(width), 8'(PULSE));
        extra = 0;
        for (int i = 0; i < 8 * SETTLE; i++) begin
            @(negedge clk);
            if (!irq_n) extra++;
        end
        check("R9 no re-arm before read", 8'(extra), 8'h00);
        clear_pads();
        read_pair(c, r);
        check("R9 pulse capture column", c, 8'hC8);
        pads[2] = 6'b000001;
        wait_irq(seen);
        check("R9 re-armed after read", {7'b0, seen}, 8'h01);
        clear_pads();
        read_pair(c, r);
        pulse_mode = 1'b0;
        cycles(2);
    endtask

    task automatic test_reset_mid();
        bit seen; logic [7:0] c, r;
        pads[2] = 6'b010000;
        wait_irq(seen);
        do_reset();
        @(negedge clk);
        check("R10 reset clears irq", {7'b0, irq_n}, 8'h01);
        read_pair(c, r);
        check("R10 reset clears column", c, 8'hFF);
        check("R10 reset clears row", r, 8'hFF);
    endtask

    initial begin
        clear_pads();
        @(negedge clk);
        test_reset_scan();
        test_capture_read();
        test_hold();
        test_other_device();
        test_write_ack();
        test_multi();
        test_pulse();
        test_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule